// File: doc/BRIEF.md
# Configuration Request Address Translator

This block sits between a root port's configuration access path and its outbound address fabric. A request names a bus, device, function, register offset and access size (byte, word or dword), and is either a read or a write. The block first decides whether the target can exist behind the port. It then picks the configuration request type from the bus number. Bus 0 requests are steered to the local register block. Requests for any other bus are steered into a fixed window at the top of the outbound space, and the block builds the routing field that the window carries as its target.

A small programmable region (base, limit, kept low target bits, type code and enable) decides whether window traffic may go out. A target that is topologically impossible, or a window address the region does not admit, never reaches the fabric. A rejected read answers with all ones and a rejected write is dropped. Both carry an error flag. Byte and word accesses are carried as one dword with byte enables, with the data lanes shifted into place.

A state machine sequences each request:
- `S_IDLE` accepts a request (transition *accept*, to `S_CHECK`).
- `S_CHECK` makes and registers the decision. It goes to `S_ISSUE` on *pass* or to `S_REPLY` on *reject*.
- `S_ISSUE` holds the fabric request until acknowledged (*ack*, to `S_REPLY`).
- `S_REPLY` presents the one-cycle response (*finish*, back to `S_IDLE`).

Top module: `cfgx_xlate`

## Requirements
- R1: After reset `req_ready` is 1 and `fab_valid` and `rsp_valid` are 0.
- R2: On bus 0 only device numbers 0 and 1 exist, and on bus 1 only device 0 exists. A request to any other device on those two buses is rejected with `rsp_err`=1 and never raises `fab_valid`.
- R3: `fab_type` is 5'h04 (type 0 configuration) for buses 0 and 1, and 5'h05 (type 1) for buses 2 and above.
- R4: A bus 0 request goes to `LOCAL_BASE` plus the offset rounded down to a multiple of 4, with `fab_target` 0. It is not subject to the region check.
- R5: A request for any other bus goes to `OUT_BASE + OUT_SPAN - WIN_SPAN` (0x01F0_0000 by default) plus the offset rounded down to a multiple of 4. `fab_target` is then {bus in 31:24, device in 23:19, function in 18:16, programmed target bits in 15:0}.
- R6: A window request passes only if the region enable is 1, the programmed type code is 5'h04 or 5'h05, and the window address lies between base and limit with both ends inclusive. Otherwise it is rejected with `rsp_err`=1.
- R7: A rejected read returns `rsp_rdata` 0xFFFF_FFFF. A rejected write produces no fabric request.
- R8: Size code 0 is a byte, with lane offset[1:0] and `fab_be` = 1 shifted left by the lane. Size code 1 is a word, with lane {offset[1],0} and `fab_be` = 3 shifted left by the lane. Size codes 2 and 3 are a dword, with `fab_be` 4'hF.
- R9: `fab_wdata` is the request data shifted left by 8 times the lane. A passed read returns the fabric data shifted right by 8 times the lane, zero-extended from 8 bits for bytes and from 16 bits for words.
- R10: `fab_valid` stays high, with address, enables and data unchanged, until `fab_ack`. `rsp_valid` follows for exactly one cycle. A passed write answers `rsp_err`=0 and `rsp_rdata` 0.
- R11: Region writes use `prg_sel` codes 0 base, 1 limit, 2 target (bits 15:0 kept), 3 type (bits 4:0 kept) and 4 control (bit 31 is the enable). A region write in the decision cycle takes effect only for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` |
| req_ready | output | 1 | Block is idle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data, right-aligned |
| prg_we | input | 1 | Region register write strobe |
| prg_sel | input | 3 | Region register select |
| prg_wdata | input | 32 | Region register write data |
| fab_valid | output | 1 | Outbound request valid |
| fab_ack | input | 1 | Outbound request completed |
| fab_write | output | 1 | Outbound request is a write |
| fab_addr | output | 32 | Outbound address |
| fab_type | output | 5 | Request type code |
| fab_target | output | 32 | Translated target field |
| fab_be | output | 4 | Byte enables |
| fab_wdata | output | 32 | Lane-placed write data |
| fab_rdata | input | 32 | Read data, valid with `fab_ack` |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read result |

## Verification
Two things can land on the same clock edge: software reprogramming the region, and the decision for a window request that is in flight. The bench provokes this by issuing the region write in exactly the cycle the machine spends in `S_CHECK`. It does this both for turning the region off and for turning it back on. It then expects the in-flight request to follow the old setting and the next request to follow the new one. Fabric stalls of several cycles overlap random mixes of sizes, buses and invalid devices, and each response is judged against a bench model of the rules.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int CFGX_AW     = 32;
    localparam int CFGX_TGT_W  = 16;
    localparam int CTRL_EN_BIT = 31;

    localparam logic [4:0] CFGX_TYPE0 = 5'h04;
    localparam logic [4:0] CFGX_TYPE1 = 5'h05;

    localparam logic [2:0] SEL_BASE  = 3'd0;
    localparam logic [2:0] SEL_LIMIT = 3'd1;
    localparam logic [2:0] SEL_TGT   = 3'd2;
    localparam logic [2:0] SEL_TYPE  = 3'd3;
    localparam logic [2:0] SEL_CTRL  = 3'd4;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CHECK,
        S_ISSUE,
        S_REPLY
    } cfgx_state_e;

    typedef struct packed {
        logic [CFGX_AW-1:0]    base;
        logic [CFGX_AW-1:0]    limit;
        logic [CFGX_TGT_W-1:0] tgt;
        logic [4:0]            rtype;
        logic                  en;
    } cfgx_region_t;

endpackage

// File: rtl/cfgx_region.sv
module cfgx_region
    import cfgx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prg_we,
    input  logic [2:0]         prg_sel,
    input  logic [CFGX_AW-1:0] prg_wdata,
    output cfgx_region_t       region
);

    cfgx_region_t r_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else if (prg_we) begin
            case (prg_sel)
                SEL_BASE:  r_q.base  <= prg_wdata;
                SEL_LIMIT: r_q.limit <= prg_wdata;
                SEL_TGT:   r_q.tgt   <= prg_wdata[CFGX_TGT_W-1:0];
                SEL_TYPE:  r_q.rtype <= prg_wdata[4:0];
                SEL_CTRL:  r_q.en    <= prg_wdata[CTRL_EN_BIT];
                default:   r_q       <= r_q;
            endcase
        end
    end

    assign region = r_q;

endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter logic [CFGX_AW-1:0] LOCAL_BASE = 32'h01FF_C000,
    parameter logic [CFGX_AW-1:0] WIN_BASE   = 32'h01F0_0000,
    parameter int BUS_W     = 8,
    parameter int DEV_W     = 5,
    parameter int FN_W      = 3,
    parameter int OFF_W     = 12,
    parameter int BUS0_DEVS = 2,
    parameter int BUS1_DEVS = 1,
    parameter int CFG1_BUS  = 2
) (
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEV_W-1:0]   dev,
    input  logic [FN_W-1:0]    func,
    input  logic [OFF_W-1:0]   off,
    input  cfgx_region_t       region,
    output logic               reject,
    output logic [4:0]         ctype,
    output logic [CFGX_AW-1:0] addr,
    output logic [CFGX_AW-1:0] target
);

    localparam int TGT_LO_W = CFGX_AW - BUS_W - DEV_W - FN_W;

    logic [CFGX_AW-1:0] aligned;
    logic               is_local;
    logic               topo_ok;
    logic               type_ok;
    logic               win_ok;

    assign aligned  = {{(CFGX_AW-OFF_W){1'b0}}, off[OFF_W-1:2], 2'b00};
    assign is_local = (bus == '0);

    always_comb begin
        if (bus == BUS_W'(0)) begin
            topo_ok = (dev < DEV_W'(BUS0_DEVS));
        end else if (bus == BUS_W'(1)) begin
            topo_ok = (dev < DEV_W'(BUS1_DEVS));
        end else begin
            topo_ok = 1'b1;
        end
    end

    assign ctype   = (bus < BUS_W'(CFG1_BUS)) ? CFGX_TYPE0 : CFGX_TYPE1;
    assign addr    = is_local ? (LOCAL_BASE + aligned) : (WIN_BASE + aligned);
    assign type_ok = (region.rtype == CFGX_TYPE0) || (region.rtype == CFGX_TYPE1);
    assign win_ok  = region.en && type_ok
                     && (addr >= region.base) && (addr <= region.limit);
    assign reject  = !topo_ok || (!is_local && !win_ok);
    assign target  = is_local ? '0
                              : {bus, dev, func, region.tgt[TGT_LO_W-1:0]};

endmodule

// File: rtl/cfgx_lanes.sv
module cfgx_lanes #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]            size,
    input  logic [LW-1:0]         sel,
    input  logic [DATA_W-1:0]     wdata_in,
    input  logic [DATA_W-1:0]     rdata_raw,
    output logic [DATA_W/8-1:0]   be,
    output logic [DATA_W-1:0]     wdata_out,
    output logic [DATA_W-1:0]     rdata_out
);

    localparam int LANES = DATA_W / 8;
    localparam int LW    = $clog2(LANES);

    logic [LW-1:0]     lane;
    logic [LW+2:0]     shamt;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        case (size)
            2'd0:    lane = sel;
            2'd1:    lane = {sel[LW-1:1], 1'b0};
            default: lane = '0;
        endcase
    end

    assign shamt = {lane, 3'b000};

    always_comb begin
        case (size)
            2'd0:    be = LANES'(1) << lane;
            2'd1:    be = LANES'(3) << lane;
            default: be = '1;
        endcase
    end

    assign wdata_out = wdata_in << shamt;
    assign shifted   = rdata_raw >> shamt;

    always_comb begin
        case (size)
            2'd0:    rdata_out = {{(DATA_W-8){1'b0}},  shifted[7:0]};
            2'd1:    rdata_out = {{(DATA_W-16){1'b0}}, shifted[15:0]};
            default: rdata_out = shifted;
        endcase
    end

endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
    import cfgx_pkg::*;
#(
    parameter logic [CFGX_AW-1:0] LOCAL_BASE = 32'h01FF_C000,
    parameter logic [CFGX_AW-1:0] OUT_BASE   = 32'h0100_0000,
    parameter logic [CFGX_AW-1:0] OUT_SPAN   = 32'h0100_0000,
    parameter logic [CFGX_AW-1:0] WIN_SPAN   = 32'h0010_0000,
    parameter int BUS_W     = 8,
    parameter int DEV_W     = 5,
    parameter int FN_W      = 3,
    parameter int OFF_W     = 12,
    parameter int BUS0_DEVS = 2,
    parameter int BUS1_DEVS = 1,
    parameter int CFG1_BUS  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEV_W-1:0]   req_dev,
    input  logic [FN_W-1:0]    req_func,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [31:0]        req_wdata,
    input  logic               prg_we,
    input  logic [2:0]         prg_sel,
    input  logic [31:0]        prg_wdata,
    output logic               fab_valid,
    input  logic               fab_ack,
    output logic               fab_write,
    output logic [31:0]        fab_addr,
    output logic [4:0]         fab_type,
    output logic [31:0]        fab_target,
    output logic [3:0]         fab_be,
    output logic [31:0]        fab_wdata,
    input  logic [31:0]        fab_rdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [31:0]        rsp_rdata
);

    localparam logic [CFGX_AW-1:0] WIN_BASE = OUT_BASE + OUT_SPAN - WIN_SPAN;
    localparam int DATA_W = 32;

    cfgx_state_e        state_q, state_d;

    logic               q_write;
    logic [1:0]         q_size;
    logic [BUS_W-1:0]   q_bus;
    logic [DEV_W-1:0]   q_dev;
    logic [FN_W-1:0]    q_func;
    logic [OFF_W-1:0]   q_off;
    logic [DATA_W-1:0]  q_wdata;
    logic [DATA_W-1:0]  q_rdata;

    logic               dq_reject;
    logic [4:0]         dq_type;
    logic [CFGX_AW-1:0] dq_addr;
    logic [CFGX_AW-1:0] dq_tgt;

    cfgx_region_t       region;
    logic               dc_reject;
    logic [4:0]         dc_type;
    logic [CFGX_AW-1:0] dc_addr;
    logic [CFGX_AW-1:0] dc_tgt;

    logic [3:0]         ln_be;
    logic [DATA_W-1:0]  ln_wdata;
    logic [DATA_W-1:0]  ln_rdata;

    cfgx_region u_region (
        .clk       (clk),
        .rst_n     (rst_n),
        .prg_we    (prg_we),
        .prg_sel   (prg_sel),
        .prg_wdata (prg_wdata),
        .region    (region)
    );

    cfgx_decode #(
        .LOCAL_BASE (LOCAL_BASE),
        .WIN_BASE   (WIN_BASE),
        .BUS_W      (BUS_W),
        .DEV_W      (DEV_W),
        .FN_W       (FN_W),
        .OFF_W      (OFF_W),
        .BUS0_DEVS  (BUS0_DEVS),
        .BUS1_DEVS  (BUS1_DEVS),
        .CFG1_BUS   (CFG1_BUS)
    ) u_decode (
        .bus    (q_bus),
        .dev    (q_dev),
        .func   (q_func),
        .off    (q_off),
        .region (region),
        .reject (dc_reject),
        .ctype  (dc_type),
        .addr   (dc_addr),
        .target (dc_tgt)
    );

    cfgx_lanes #(
        .DATA_W (DATA_W)
    ) u_lanes (
        .size      (q_size),
        .sel       (q_off[1:0]),
        .wdata_in  (q_wdata),
        .rdata_raw (q_rdata),
        .be        (ln_be),
        .wdata_out (ln_wdata),
        .rdata_out (ln_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept, pass, reject, ack, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_CHECK;
            S_CHECK: state_d = dc_reject ? S_REPLY : S_ISSUE;
            S_ISSUE: if (fab_ack) state_d = S_REPLY;
            S_REPLY: state_d = S_IDLE;
        endcase
    end

    // request capture, decision capture and read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write   <= 1'b0;
            q_size    <= '0;
            q_bus     <= '0;
            q_dev     <= '0;
            q_func    <= '0;
            q_off     <= '0;
            q_wdata   <= '0;
            q_rdata   <= '0;
            dq_reject <= 1'b0;
            dq_type   <= '0;
            dq_addr   <= '0;
            dq_tgt    <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                q_write <= req_write;
                q_size  <= req_size;
                q_bus   <= req_bus;
                q_dev   <= req_dev;
                q_func  <= req_func;
                q_off   <= req_off;
                q_wdata <= req_wdata;
            end
            if (state_q == S_CHECK) begin
                dq_reject <= dc_reject;
                dq_type   <= dc_type;
                dq_addr   <= dc_addr;
                dq_tgt    <= dc_tgt;
            end
            if (state_q == S_ISSUE && fab_ack) begin
                q_rdata <= fab_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        fab_valid  = 1'b0;
        rsp_valid  = 1'b0;
        unique case (state_q)
            S_IDLE:  req_ready = 1'b1;
            S_CHECK: ;
            S_ISSUE: fab_valid = 1'b1;
            S_REPLY: rsp_valid = 1'b1;
        endcase
        fab_write  = q_write;
        fab_addr   = dq_addr;
        fab_type   = dq_type;
        fab_target = dq_tgt;
        fab_be     = ln_be;
        fab_wdata  = ln_wdata;
        rsp_err    = dq_reject;
        if (q_write) begin
            rsp_rdata = '0;
        end else if (dq_reject) begin
            rsp_rdata = '1;
        end else begin
            rsp_rdata = ln_rdata;
        end
    end

    // R3
    fab_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fab_valid |-> (fab_type == CFGX_TYPE0 || fab_type == CFGX_TYPE1));

    // R7
    rej_nofab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && rsp_err) |-> !$past(fab_valid));

    // R8
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fab_valid |-> ($countones(fab_be) == 1 || $countones(fab_be) == 2
                       || $countones(fab_be) == 4));

    // R10
    fab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fab_valid && !fab_ack) |=> (fab_valid && $stable(fab_addr)
                                     && $stable(fab_be) && $stable(fab_wdata)));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: tb/tb_cfgx_xlate.sv
`timescale 1ns/1ps
module tb_cfgx_xlate;

    localparam logic [31:0] LOCB = 32'h01FF_C000;
    localparam logic [31:0] WINB = 32'h01F0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [11:0] req_off = '0;
    logic [31:0] req_wdata = '0;
    logic        prg_we = 1'b0;
    logic [2:0]  prg_sel = '0;
    logic [31:0] prg_wdata = '0;
    logic        fab_valid;
    logic        fab_ack = 1'b0;
    logic        fab_write;
    logic [31:0] fab_addr;
    logic [4:0]  fab_type;
    logic [31:0] fab_target;
    logic [3:0]  fab_be;
    logic [31:0] fab_wdata;
    logic [31:0] fab_rdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_base = '0, m_limit = '0;
    logic [15:0] m_tgt = '0;
    logic [4:0]  m_type = '0;
    logic        m_en = 1'b0;

    always #2.5 clk = ~clk;

    cfgx_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_bus(req_bus), .req_dev(req_dev),
        .req_func(req_func), .req_off(req_off), .req_wdata(req_wdata),
        .prg_we(prg_we), .prg_sel(prg_sel), .prg_wdata(prg_wdata),
        .fab_valid(fab_valid), .fab_ack(fab_ack), .fab_write(fab_write),
        .fab_addr(fab_addr), .fab_type(fab_type), .fab_target(fab_target),
        .fab_be(fab_be), .fab_wdata(fab_wdata), .fab_rdata(fab_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic shadow(input logic [2:0] sel, input logic [31:0] d);
        case (sel)
            3'd0: m_base  = d;
            3'd1: m_limit = d;
            3'd2: m_tgt   = d[15:0];
            3'd3: m_type  = d[4:0];
            3'd4: m_en    = d[31];
            default: ;
        endcase
    endtask

    task automatic prog(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        prg_we = 1'b1; prg_sel = sel; prg_wdata = d;
        @(negedge clk);
        prg_we = 1'b0;
        shadow(sel, d);
    endtask

    task automatic run_req(input bit w, input logic [1:0] sz, input logic [7:0] bus,
                           input logic [4:0] dev, input logic [2:0] fn,
                           input logic [11:0] off, input logic [31:0] wd,
                           input logic [31:0] fd, input int dly,
                           input bit mid, input logic [2:0] msel,
                           input logic [31:0] mdata, input string tag);
        logic [1:0]  lane;
        logic [3:0]  ebe;
        logic [31:0] eaddr, etgt, ewd, sh, erd;
        logic [4:0]  etype;
        bit topo, wok, erej, saw, done;
        int cyc;
        lane = (sz == 2'd0) ? off[1:0] : (sz == 2'd1) ? {off[1], 1'b0} : 2'd0;
        ebe  = (sz == 2'd0) ? (4'b0001 << lane) : (sz == 2'd1) ? (4'b0011 << lane) : 4'hF;
        topo = (bus == 8'd0) ? (dev < 5'd2) : (bus == 8'd1) ? (dev == 5'd0) : 1'b1;
        eaddr = ((bus == 8'd0) ? LOCB : WINB) + {20'd0, off[11:2], 2'b00};
        wok  = m_en && (m_type == 5'h04 || m_type == 5'h05)
               && eaddr >= m_base && eaddr <= m_limit;
        erej = !topo || (bus != 8'd0 && !wok);
        etype = (bus < 8'd2) ? 5'h04 : 5'h05;
        etgt = (bus == 8'd0) ? 32'd0 : {bus, dev, fn, m_tgt};
        ewd  = wd << (8 * lane);
        sh   = fd >> (8 * lane);
        if (w) erd = 32'd0;
        else if (erej) erd = 32'hFFFF_FFFF;
        else if (sz == 2'd0) erd = sh & 32'hFF;
        else if (sz == 2'd1) erd = sh & 32'hFFFF;
        else erd = sh;

        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_size = sz; req_bus = bus;
        req_dev = dev; req_func = fn; req_off = off; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (mid) begin
            prg_we = 1'b1; prg_sel = msel; prg_wdata = mdata;
        end
        saw = 1'b0; done = 1'b0; cyc = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            prg_we = 1'b0;
            cyc++;
            if (fab_valid && !saw) begin
                saw = 1'b1;
                chk(fab_addr == eaddr, {tag, " addr"}, fab_addr, eaddr);
                chk(fab_type == etype, {tag, " R3 type"}, {27'd0, fab_type}, {27'd0, etype});
                chk(fab_target == etgt, {tag, " target"}, fab_target, etgt);
                chk(fab_be == ebe, {tag, " R8 be"}, {28'd0, fab_be}, {28'd0, ebe});
                chk(fab_write == w, {tag, " write"}, {31'd0, fab_write}, {31'd0, w});
                if (w) chk(fab_wdata == ewd, {tag, " R9 wdata"}, fab_wdata, ewd);
                for (int k = 0; k < dly; k++) begin
                    @(negedge clk);
                    chk(fab_valid && fab_addr == eaddr && fab_be == ebe,
                        {tag, " R10 hold"}, fab_addr, eaddr);
                end
                fab_ack = 1'b1; fab_rdata = fd;
                @(negedge clk);
                fab_ack = 1'b0;
            end
            if (rsp_valid) begin
                done = 1'b1;
                chk(rsp_err == erej, {tag, " err"}, {31'd0, rsp_err}, {31'd0, erej});
                chk(rsp_rdata == erd, {tag, " rdata"}, rsp_rdata, erd);
                chk(saw == !erej, {tag, " R7 fabric use"}, {31'd0, saw}, {31'd0, !erej});
            end
        end
        if (mid) shadow(msel, mdata);
        chk(done, {tag, " R10 response seen"}, {31'd0, done}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7133));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
        chk(fab_valid == 1'b0, "R1 fab_valid", {31'd0, fab_valid}, 32'd0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // bus 0 passes while the window is still off
        run_req(0, 2'd2, 8'd0, 5'd1, 3'd2, 12'h013, 0, 32'hCAFE_0001, 0, 0, 0, 0, "R4 local");

        prog(3'd0, WINB);
        prog(3'd1, WINB + 32'h000F_FFFF);
        prog(3'd2, 32'hABCD_1234);
        prog(3'd3, 32'h0000_0004);
        prog(3'd4, 32'h8000_0000);

        run_req(0, 2'd2, 8'd0, 5'd2, 3'd0, 12'h010, 0, 32'h1111_2222, 0, 0, 0, 0, "R2 R7 bus0 dev2");
        run_req(1, 2'd2, 8'd1, 5'd1, 3'd0, 12'h010, 32'h55, 0, 0, 0, 0, 0, "R2 R7 bus1 dev1");
        run_req(0, 2'd1, 8'd1, 5'd0, 3'd3, 12'h00F, 0, 32'hBEEF_1234, 0, 0, 0, 0, "R5 R8 R9 word");
        run_req(1, 2'd0, 8'd3, 5'd7, 3'd5, 12'h103, 32'h0000_00A5, 0, 0, 0, 0, 0, "R3 R5 R9 byte");
        run_req(0, 2'd0, 8'd2, 5'd4, 3'd1, 12'h102, 0, 32'h0077_6655, 0, 0, 0, 0, "R9 byte read");

        prog(3'd1, WINB + 32'h0000_00FF);
        run_req(0, 2'd2, 8'd2, 5'd0, 3'd0, 12'h0FC, 0, 32'h0BAD_F00D, 0, 0, 0, 0, "R6 limit edge");
        run_req(0, 2'd2, 8'd2, 5'd0, 3'd0, 12'h100, 0, 32'h0BAD_F00D, 0, 0, 0, 0, "R6 past limit");
        prog(3'd1, WINB + 32'h000F_FFFF);

        prog(3'd3, 32'h0000_0000);
        run_req(0, 2'd2, 8'd4, 5'd0, 3'd0, 12'h040, 0, 32'h1, 0, 0, 0, 0, "R6 bad type");
        prog(3'd3, 32'h0000_0005);

        run_req(1, 2'd2, 8'd5, 5'd9, 3'd7, 12'h200, 32'h1234_5678, 0, 3, 0, 0, 0, "R10 stall write");

        // region write colliding with the decision cycle
        run_req(0, 2'd2, 8'd2, 5'd1, 3'd0, 12'h020, 0, 32'h5A5A_5A5A, 0, 1, 3'd4, 32'h0, "R11 off mid");
        run_req(0, 2'd2, 8'd2, 5'd1, 3'd0, 12'h020, 0, 32'h5A5A_5A5A, 0, 1, 3'd4, 32'h8000_0000, "R11 on mid");
        run_req(0, 2'd2, 8'd2, 5'd1, 3'd0, 12'h020, 0, 32'h5A5A_5A5A, 0, 0, 0, 0, "R11 after on");

        for (int i = 0; i < 240; i++) begin
            logic [7:0] b;
            int pick;
            if (i % 60 == 59) prog(3'd1, WINB + {20'd0, 12'($urandom)});
            pick = $urandom % 4;
            b = (pick == 0) ? 8'd0 : (pick == 1) ? 8'd1 : 8'(2 + ($urandom % 200));
            run_req(1'($urandom), 2'($urandom), b, 5'($urandom % 4), 3'($urandom),
                    12'($urandom), $urandom, $urandom, $urandom % 3, 0, 0, 0,
                    "R2 R5 R6 R8 R9 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule